// File: doc/BRIEF.md
# PAM4 Termination-Grid and Frame Synchronizer

This receive-side, per-lane block takes one sliced PAM4 decision per cycle and finds the transmit framing in two steps. First it finds the termination grid. One symbol in every row of `SYMS` symbols is driven only to an outer level, so the block hunts for the symbol position that shows an outer level in every row. Once that grid is held, it looks for the row that opens a frame. It does this by comparing the two decoded overhead symbols at the head of a candidate row against a known 4-bit pattern, and it repeats that comparison every `ROWS` rows.

While both locks are held, the block undoes the transmit precoder with a (1+D) modulo-4 decoder. It removes the overhead symbols and passes the one data bit that each termination symbol carries. It emits payload as up to two bits per cycle, each bit with its own valid strobe, and it raises a pulse on the first payload symbol of every frame. The equalizer, the slicer and the FEC decoder sit outside this block.

Top module: `pam4_term_frame_sync`

## Requirements
- R1: While `rst_n` is low and after its release until frame lock, `dout_vld`, `frame_start` and `frame_lock` stay 0; `term_lock` stays 0 during reset.
- R2: Symbol codes 00 and 10 are outer levels; 01 and 11 are inner levels. While hunting, the candidate is the last symbol of the current row. A candidate that holds an inner level makes the candidate move one symbol later (slip). `term_lock` rises after `TL_GOOD` consecutive outer candidates.
- R3: While `term_lock` is high, each window of `TL_WIN` candidates is checked. `TL_BAD` inner-level candidates in one window drop `term_lock` and cause a slip. Fewer inner-level candidates than that leave the lock held.
- R4: The overhead is the first two symbols of a frame's first row, after decoding. The first symbol holds pattern bits [3:2] and the second holds bits [1:0], compared against `OH_PAT`. Frame lock needs a match on `FR_GOOD` consecutive frames. It is possible only while `term_lock` is high, and losing `term_lock` also clears `frame_lock`.
- R5: Once frame lock is reached, `FR_BAD` consecutive mismatching frames clear `frame_lock`. Fewer mismatches than that do not clear it.
- R6: Codes map to level indices as 00→0, 01→1, 11→2, 10→3. A payload symbol is decoded as r = (level(d) + level(d_prev)) mod 4, where d_prev is the previous valid symbol of any kind. The result is output one cycle later as the code of r, with `dout[1]` as the first bit and `dout_vld`=11.
- R7: A termination symbol yields a single bit, its first code bit, on `dout[1]` with `dout_vld`=10. Its second bit is dropped.
- R8: Payload is output only while frame-locked, and the two overhead symbols are never output. Each frame carries exactly 63·`ROWS`−4 payload bits.
- R9: `frame_start` is high together with the first payload symbol of each frame, which is the third symbol of row 0, and `dout_vld` is 11 in that cycle.
- R10: A cycle with `sym_vld` low changes no state and produces `dout_vld`=00 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sym_vld | input | 1 | A sliced symbol is present this cycle |
| sym | input | 2 | Sliced Gray level code |
| dout | output | 2 | Decoded payload bits, `dout[1]` first |
| dout_vld | output | 2 | Per-bit valid for `dout` |
| frame_start | output | 1 | First payload symbol of a frame |
| term_lock | output | 1 | Termination grid held |
| frame_lock | output | 1 | Frame boundary held |

## Verification
The bench builds the block with `ROWS`=4, `TL_GOOD`=16, `TL_WIN`=16, `TL_BAD`=4 and `OH_PAT`=1101, with `FR_GOOD` and `FR_BAD` at 4. With these values a full frame is 128 symbols, and termination lock takes 16 rows instead of 64. Every lock, relock and loss path can therefore be reached repeatedly within a short run. A transmitter model in the bench precodes hashed payload that changes from frame to frame, and it starts away from the grid so that the hunt must slip. It then corrupts overhead and termination symbols in counted bursts that sit on both sides of each loss threshold, and it inserts idle cycles. Every payload bit is compared against its arithmetic expectation.

// File: rtl/pam4_tfs_pkg.sv
// Shared types and Gray/level conversions for the PAM4 termination and frame
// synchronizer. Assumes codes 00,01,11,10 name levels from lowest to highest.
package pam4_tfs_pkg;

    typedef enum logic {
        TS_HUNT = 1'b0,
        TS_LOCK = 1'b1
    } term_state_e;

    typedef enum logic [1:0] {
        FS_HUNT = 2'd0,
        FS_CONF = 2'd1,
        FS_LOCK = 2'd2
    } frame_state_e;

    // Gray code to level index (0 = lowest level, 3 = highest)
    function automatic logic [1:0] code_to_level(input logic [1:0] c);
        case (c)
            2'b00:   return 2'd0;
            2'b01:   return 2'd1;
            2'b11:   return 2'd2;
            default: return 2'd3;
        endcase
    endfunction

    // Level index back to Gray code
    function automatic logic [1:0] level_to_code(input logic [1:0] l);
        case (l)
            2'd0:    return 2'b00;
            2'd1:    return 2'b01;
            2'd2:    return 2'b11;
            default: return 2'b10;
        endcase
    endfunction

endpackage

// File: rtl/pam4_term_hunt.sv
// Termination-grid hunt. Tracks the symbol position within a row and tests
// the last position of each row for an outer level (code bit 0 clear).
// Hunting: any inner-level candidate slips the grid by one symbol. Locked:
// a window of TL_WIN candidates may hold fewer than TL_BAD failures.
// Assumes at most one symbol per clock, qualified by sym_vld.
module pam4_term_hunt
    import pam4_tfs_pkg::*;
#(
    parameter int SYMS    = 32,
    parameter int TL_GOOD = 64,
    parameter int TL_WIN  = 64,
    parameter int TL_BAD  = 16,
    localparam int PW     = $clog2(SYMS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sym_vld,
    input  logic [1:0]    sym,
    output logic [PW-1:0] pos,
    output logic          term_lock
);

    localparam int GW = $clog2(TL_GOOD + 1);
    localparam int WW = $clog2(TL_WIN + 1);
    localparam int BW = $clog2(TL_BAD + 1);
    localparam logic [PW-1:0] LAST   = PW'(SYMS - 1);
    localparam logic [GW-1:0] G_LAST = GW'(TL_GOOD - 1);
    localparam logic [WW-1:0] W_LAST = WW'(TL_WIN - 1);
    localparam logic [BW-1:0] B_LAST = BW'(TL_BAD - 1);

    term_state_e   st_q;
    logic [PW-1:0] pos_q;
    logic [GW-1:0] good_q;
    logic [WW-1:0] win_q;
    logic [BW-1:0] bad_q;
    logic          cand, outer, hunt_done, lose, slip;

    // Candidate decode and slip decision for the current symbol
    always_comb begin
        cand      = sym_vld && (pos_q == LAST);
        outer     = ~sym[0];
        hunt_done = (st_q == TS_HUNT) && cand && outer && (good_q == G_LAST);
        lose      = (st_q == TS_LOCK) && cand && !outer && (bad_q == B_LAST);
        slip      = ((st_q == TS_HUNT) && cand && !outer) || lose;
    end

    // Symbol position within the row; a slip holds it for one symbol
    always_ff @(posedge clk) begin
        if (!rst_n)
            pos_q <= '0;
        else if (sym_vld && !slip)
            pos_q <= (pos_q == LAST) ? '0 : pos_q + 1'b1;
    end

    // Hunt/lock state machine with good run, window and failure counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= TS_HUNT;
            good_q <= '0;
            win_q  <= '0;
            bad_q  <= '0;
        end else if (cand) begin
            case (st_q)
                TS_HUNT: begin
                    if (!outer) begin
                        good_q <= '0;
                    end else if (hunt_done) begin
                        st_q   <= TS_LOCK;
                        good_q <= '0;
                        win_q  <= '0;
                        bad_q  <= '0;
                    end else begin
                        good_q <= good_q + 1'b1;
                    end
                end
                default: begin
                    if (lose) begin
                        st_q  <= TS_HUNT;
                        win_q <= '0;
                        bad_q <= '0;
                    end else if (win_q == W_LAST) begin
                        win_q <= '0;
                        bad_q <= '0;
                    end else begin
                        win_q <= win_q + 1'b1;
                        bad_q <= bad_q + {{(BW-1){1'b0}}, ~outer};
                    end
                end
            endcase
        end
    end

    assign pos       = pos_q;
    assign term_lock = (st_q == TS_LOCK);

    // R2: an inner level at a hunted candidate keeps the candidate on the next symbol
    p_slip_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cand && !outer && !term_lock) |=> (pos_q == LAST));

    // R3: lock falls only on a failing candidate
    p_drop_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(term_lock) |-> $past(cand && !outer));

    // R2: lock rises only on a passing candidate
    p_rise_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(term_lock) |-> $past(cand && outer));

    // R10: idle cycles leave position and lock unchanged
    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !sym_vld |=> ($stable(pos_q) && $stable(term_lock)));

endmodule

// File: rtl/pam4_diff_decode.sv
// (1+D) modulo-4 decoder. Adds the level of the current symbol to the level
// of the previous valid symbol, whatever its role, and returns the Gray code
// of the sum. Assumes sym_vld qualifies sym.
module pam4_diff_decode
    import pam4_tfs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sym_vld,
    input  logic [1:0] sym,
    output logic [1:0] dec_code
);

    logic [1:0] prev_lvl_q;
    logic [1:0] cur_lvl;
    logic [1:0] sum_lvl;

    // Modulo-4 sum of the current and previous level indices
    always_comb begin
        cur_lvl  = code_to_level(sym);
        sum_lvl  = cur_lvl + prev_lvl_q;
        dec_code = level_to_code(sum_lvl);
    end

    // Remember the level of the last valid symbol
    always_ff @(posedge clk) begin
        if (!rst_n)
            prev_lvl_q <= '0;
        else if (sym_vld)
            prev_lvl_q <= cur_lvl;
    end

endmodule

// File: rtl/pam4_frame_align.sv
// Frame alignment on top of the termination grid. Keeps the row count and
// compares the two decoded overhead symbols with OH_PAT. Hunting tests every
// row; confirming and locked test only row 0 of each frame. Assumes pos is
// valid whenever term_lock is high.
module pam4_frame_align
    import pam4_tfs_pkg::*;
#(
    parameter int           SYMS    = 32,
    parameter int           ROWS    = 88,
    parameter int           FR_GOOD = 4,
    parameter int           FR_BAD  = 4,
    parameter logic [3:0]   OH_PAT  = 4'b1001,
    localparam int          PW      = $clog2(SYMS),
    localparam int          RW      = $clog2(ROWS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sym_vld,
    input  logic [PW-1:0] pos,
    input  logic          term_lock,
    input  logic [1:0]    dec_code,
    output logic [RW-1:0] row,
    output logic          frame_lock
);

    localparam int CMAX = (FR_GOOD > FR_BAD) ? FR_GOOD : FR_BAD;
    localparam int CW   = $clog2(CMAX + 1);
    localparam logic [PW-1:0] LAST   = PW'(SYMS - 1);
    localparam logic [RW-1:0] R_LAST = RW'(ROWS - 1);
    localparam logic [CW-1:0] G_LAST = CW'(FR_GOOD - 1);
    localparam logic [CW-1:0] B_LAST = CW'(FR_BAD - 1);

    frame_state_e  st_q;
    logic [RW-1:0] row_q;
    logic [CW-1:0] cnt_q;
    logic [1:0]    oh_first_q;
    logic          at_oh2, match, check;

    // Overhead comparison point and result
    always_comb begin
        at_oh2 = sym_vld && term_lock && (pos == PW'(1));
        match  = ({oh_first_q, dec_code} == OH_PAT);
        check  = at_oh2 && ((st_q == FS_HUNT) || (row_q == '0));
    end

    // Hold the first decoded overhead symbol of every row
    always_ff @(posedge clk) begin
        if (!rst_n)
            oh_first_q <= '0;
        else if (sym_vld && (pos == '0))
            oh_first_q <= dec_code;
    end

    // Row counter; a hunting match marks the current row as row 0
    always_ff @(posedge clk) begin
        if (!rst_n || !term_lock)
            row_q <= '0;
        else if (check && (st_q == FS_HUNT) && match)
            row_q <= '0;
        else if (sym_vld && (pos == LAST))
            row_q <= (row_q == R_LAST) ? '0 : row_q + 1'b1;
    end

    // Hunt / confirm / lock state machine
    always_ff @(posedge clk) begin
        if (!rst_n || !term_lock) begin
            st_q  <= FS_HUNT;
            cnt_q <= '0;
        end else if (check) begin
            case (st_q)
                FS_HUNT: begin
                    if (match) begin
                        st_q  <= (FR_GOOD <= 1) ? FS_LOCK : FS_CONF;
                        cnt_q <= (FR_GOOD <= 1) ? '0 : CW'(1);
                    end
                end
                FS_CONF: begin
                    if (!match) begin
                        st_q  <= FS_HUNT;
                        cnt_q <= '0;
                    end else if (cnt_q == G_LAST) begin
                        st_q  <= FS_LOCK;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: begin
                    if (match) begin
                        cnt_q <= '0;
                    end else if (cnt_q == B_LAST) begin
                        st_q  <= FS_HUNT;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
            endcase
        end
    end

    assign row        = row_q;
    assign frame_lock = (st_q == FS_LOCK);

    // R4: frame lock does not outlive the termination lock by more than a cycle
    p_frame_under_term_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_lock && !term_lock) |=> !frame_lock);

    // R4: frame lock is entered only on a matching overhead
    p_lock_on_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_lock) |-> $past(check && match));

    // R5: with the grid held, frame lock leaves only on a mismatching overhead
    p_drop_on_miss_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(frame_lock) && $past(term_lock)) |-> $past(check && !match));

endmodule

// File: rtl/pam4_term_frame_sync.sv
// Top of the PAM4 termination and frame synchronizer. Combines grid hunt,
// frame alignment and the (1+D) decoder, and registers the payload output:
// two bits for a data symbol, one bit for a termination symbol, nothing for
// overhead or while unlocked. Assumes one sliced symbol per clock at most.
module pam4_term_frame_sync
    import pam4_tfs_pkg::*;
#(
    parameter int         SYMS    = 32,
    parameter int         ROWS    = 88,
    parameter int         TL_GOOD = 64,
    parameter int         TL_WIN  = 64,
    parameter int         TL_BAD  = 16,
    parameter int         FR_GOOD = 4,
    parameter int         FR_BAD  = 4,
    parameter logic [3:0] OH_PAT  = 4'b1001
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sym_vld,
    input  logic [1:0] sym,
    output logic [1:0] dout,
    output logic [1:0] dout_vld,
    output logic       frame_start,
    output logic       term_lock,
    output logic       frame_lock
);

    localparam int PW = $clog2(SYMS);
    localparam int RW = $clog2(ROWS);
    localparam logic [PW-1:0] LAST = PW'(SYMS - 1);

    logic [PW-1:0] pos;
    logic [RW-1:0] row;
    logic [1:0]    dec_code;
    logic          is_term, is_oh, payload;

    pam4_term_hunt #(
        .SYMS(SYMS), .TL_GOOD(TL_GOOD), .TL_WIN(TL_WIN), .TL_BAD(TL_BAD)
    ) u_hunt (
        .clk(clk), .rst_n(rst_n), .sym_vld(sym_vld), .sym(sym),
        .pos(pos), .term_lock(term_lock)
    );

    pam4_diff_decode u_dec (
        .clk(clk), .rst_n(rst_n), .sym_vld(sym_vld), .sym(sym),
        .dec_code(dec_code)
    );

    pam4_frame_align #(
        .SYMS(SYMS), .ROWS(ROWS), .FR_GOOD(FR_GOOD), .FR_BAD(FR_BAD),
        .OH_PAT(OH_PAT)
    ) u_align (
        .clk(clk), .rst_n(rst_n), .sym_vld(sym_vld), .pos(pos),
        .term_lock(term_lock), .dec_code(dec_code),
        .row(row), .frame_lock(frame_lock)
    );

    // Classify the current symbol for output
    always_comb begin
        is_term = (pos == LAST);
        is_oh   = (row == '0) && (pos < PW'(2));
        payload = sym_vld && term_lock && frame_lock && !is_oh;
    end

    // Registered payload output stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout        <= '0;
            dout_vld    <= '0;
            frame_start <= 1'b0;
        end else begin
            dout        <= is_term ? {sym[1], 1'b0} : dec_code;
            dout_vld    <= !payload ? 2'b00 : (is_term ? 2'b10 : 2'b11);
            frame_start <= payload && (row == '0) && (pos == PW'(2));
        end
    end

    // R9: the frame-start pulse rides on a full data symbol
    p_start_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> (dout_vld == 2'b11));

    // R7: a lone second bit is never presented
    p_no_lsb_alone_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dout_vld != 2'b01);

    // R10: an idle input cycle gives an empty output cycle
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !sym_vld |=> (dout_vld == 2'b00));

    // R8: payload appears only after a cycle of frame lock
    p_out_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_vld != 2'b00) |-> $past(frame_lock));

endmodule

// File: tb/sim_pam4_term_frame_sync.sv
module sim_pam4_term_frame_sync;

    localparam int         SYMS = 32;
    localparam int         ROWS = 4;
    localparam logic [3:0] OH   = 4'b1101;
    localparam int         FS   = SYMS * ROWS;
    localparam int         FB   = 63 * ROWS - 4;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       sym_vld;
    logic [1:0] sym;
    logic [1:0] dout, dout_vld;
    logic       frame_start, term_lock, frame_lock;

    always #5 clk = ~clk;

    pam4_term_frame_sync #(
        .SYMS(SYMS), .ROWS(ROWS), .TL_GOOD(16), .TL_WIN(16), .TL_BAD(4),
        .FR_GOOD(4), .FR_BAD(4), .OH_PAT(OH)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .sym_vld(sym_vld), .sym(sym),
        .dout(dout), .dout_vld(dout_vld), .frame_start(frame_start),
        .term_lock(term_lock), .frame_lock(frame_lock)
    );

    int nchk = 0, nerr = 0, cyc = 0;
    int tpos = 50, tx_frame = 0, gapcnt = 0;
    int bad_term_left = 0, oh_bad_left = 0;
    bit gaps = 0, chk_data = 0, synced = 0, prev_fl = 0;
    int jj = 0, cfr = 0;
    logic [1:0] pprev = 2'd0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] c2l(input logic [1:0] c);
        case (c) 2'b00: return 2'd0; 2'b01: return 2'd1; 2'b11: return 2'd2; default: return 2'd3; endcase
    endfunction
    function automatic logic [1:0] l2c(input logic [1:0] l);
        case (l) 2'd0: return 2'b00; 2'd1: return 2'b01; 2'd2: return 2'b11; default: return 2'b10; endcase
    endfunction

    // Payload bit j of frame fr; rows after the first open with ~OH
    function automatic logic fbit(input int fr, input int j);
        logic [31:0] x;
        if (j >= 59 && ((j - 59) % 63) < 4)
            return ~OH[3 - ((j - 59) % 63)];
        x = 32'(fr * 1021 + j) * 32'h9E3779B1;
        x = x ^ (x >> 13);
        return x[5] ^ x[22];
    endfunction

    function automatic int jbase(input int r);
        return (r == 0) ? 0 : 59 + 63 * (r - 1);
    endfunction

    // Transmitter model: one symbol (or gap) per cycle, precoded mod 4
    task automatic tx_step();
        int r, c, j;
        logic [1:0] bits, p;
        @(negedge clk);
        gapcnt++;
        if (gaps && (gapcnt % 5 == 4)) begin
            sym_vld = 1'b0;
            return;
        end
        r = tpos / SYMS;
        c = tpos % SYMS;
        if (c == SYMS - 1) begin
            j = (r == 0) ? 58 : jbase(r) + 62;
            p = fbit(tx_frame, j) ? 2'd3 : 2'd0;
            if (bad_term_left > 0) begin
                p = 2'd1;
                bad_term_left--;
            end
        end else if (r == 0 && c < 2) begin
            bits = (c == 0) ? OH[3:2] : OH[1:0];
            if (c == 0 && oh_bad_left > 0) bits = bits ^ 2'b01;
            if (c == 1 && oh_bad_left > 0) oh_bad_left--;
            p = c2l(bits) - pprev;
        end else begin
            j = (r == 0) ? (c - 2) * 2 : jbase(r) + c * 2;
            bits = {fbit(tx_frame, j), fbit(tx_frame, j + 1)};
            p = c2l(bits) - pprev;
        end
        pprev = p;
        sym = l2c(p);
        sym_vld = 1'b1;
        tpos++;
        if (tpos == FS) begin
            tpos = 0;
            tx_frame++;
        end
    endtask

    initial begin
        sym_vld = 1'b0;
        sym = 2'b00;
        wait (rst_n === 1'b1);
        forever tx_step();
    end

    // Output checker, sampling after each active edge
    always @(posedge clk) begin
        #2;
        if (rst_n) begin
            if (dout_vld != 2'b00) begin
                check(sym_vld, "R10 output without valid input", 0, 1);
                check(prev_fl, "R8 output while not frame-locked", 0, 1);
            end
            if (!chk_data || !frame_lock) synced = 0;
            if (frame_start && chk_data && frame_lock) begin
                if (synced) check(jj == FB, "R8 payload bits per frame", jj, FB);
                check(dout_vld == 2'b11, "R9 frame start on data symbol", dout_vld, 3);
                jj = 0;
                cfr = tx_frame;
                synced = 1;
            end
            if (synced && dout_vld == 2'b10) begin
                check((jj == 58) || (jj >= 59 && (jj - 59) % 63 == 62),
                      "R7 termination bit position", jj, 58);
                check(dout[1] == fbit(cfr, jj), "R7 termination data bit", dout[1], fbit(cfr, jj));
                jj++;
            end else if (synced && dout_vld == 2'b11) begin
                check(dout == {fbit(cfr, jj), fbit(cfr, jj + 1)}, "R6 decoded pair",
                      dout, {fbit(cfr, jj), fbit(cfr, jj + 1)});
                jj += 2;
            end
            prev_fl = frame_lock;
        end
    end

    task automatic wait_for(input int which, input int lim, output bit ok);
        ok = 0;
        for (int i = 0; i < lim; i++) begin
            @(posedge clk);
            #2;
            if ((which == 0 && term_lock) || (which == 1 && frame_lock)) begin
                ok = 1;
                break;
            end
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            nerr++;
            $display("FAIL R2 watchdog actual=%0d expected<150000", cyc);
            summary();
        end
    end

    initial begin
        bit ok;
        int f0;
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        // R1: reset state
        check(dout_vld == 2'b00, "R1 dout_vld in reset", dout_vld, 0);
        check(frame_start == 1'b0, "R1 frame_start in reset", frame_start, 0);
        check(term_lock == 1'b0, "R1 term_lock in reset", term_lock, 0);
        check(frame_lock == 1'b0, "R1 frame_lock in reset", frame_lock, 0);
        rst_n = 1'b1;

        // R2: hunt from an offset start
        wait_for(0, 20000, ok);
        check(ok, "R2 termination lock reached", ok, 1);
        check(!frame_lock, "R1 no frame lock at grid lock", frame_lock, 0);
        wait_for(1, 20000, ok);
        check(ok, "R4 frame lock reached", ok, 1);

        // R6..R10: steady payload with idle gaps
        gaps = 1;
        chk_data = 1;
        f0 = tx_frame;
        wait (tx_frame == f0 + 6);
        check(frame_lock && term_lock, "R4 locks held in clean traffic", frame_lock, 1);

        // R5: three bad overhead frames tolerated, the fourth drops lock
        wait (tpos == 64);
        f0 = tx_frame;
        oh_bad_left = 4;
        wait (tx_frame == f0 + 3 && tpos == 10);
        check(frame_lock, "R5 lock held after three misses", frame_lock, 1);
        wait (tx_frame == f0 + 4 && tpos == 10);
        check(!frame_lock, "R5 lock lost after four misses", frame_lock, 0);
        check(term_lock, "R5 grid unaffected by overhead misses", term_lock, 1);
        wait_for(1, 20000, ok);
        check(ok, "R4 frame relock", ok, 1);

        // R3: three failing candidates in a window tolerated
        wait (tpos == 40);
        chk_data = 0;
        f0 = tx_frame;
        bad_term_left = 3;
        wait (tx_frame == f0 + 1 && tpos == 40);
        check(term_lock, "R3 grid held after three failures", term_lock, 1);
        check(frame_lock, "R3 frame held after three failures", frame_lock, 1);
        chk_data = 1;
        wait (tx_frame == f0 + 3);

        // R3: eight consecutive failures drop both locks
        wait (tpos == 40);
        chk_data = 0;
        f0 = tx_frame;
        bad_term_left = 8;
        wait (tx_frame == f0 + 2 && tpos == 40);
        check(!term_lock, "R3 grid lost after failures", term_lock, 0);
        check(!frame_lock, "R4 frame lost with grid", frame_lock, 0);
        wait_for(0, 20000, ok);
        check(ok, "R2 termination relock", ok, 1);
        wait_for(1, 20000, ok);
        check(ok, "R4 frame relock after grid loss", ok, 1);

        // Full-rate traffic after relock
        gaps = 0;
        chk_data = 1;
        f0 = tx_frame;
        wait (tx_frame == f0 + 4);
        check(frame_lock && term_lock, "R4 locks held at full rate", frame_lock, 1);
        summary();
    end

endmodule